// File: doc/BRIEF.md
# Multiplexed Analog Input Scan Sequencer

This block drives one shared analog-to-digital converter on behalf of a bank of analog input channels. It visits the channels one after another. For each channel it sets the multiplexer select, controls the sample-hold line for that channel, and sends the converter a one-cycle start pulse. It then waits for the converter's done pulse, stores the returned word in that channel's result register and raises that channel's fresh flag. The host clears a fresh flag by pulsing that channel's acknowledge bit.

Every channel shares the converter, so each channel is sampled at the converter's scan rate divided by the number of channels in the scan. A type bit sets how many channels are scanned. A value of 0 means single-ended wiring with the full channel count. A value of 1 means differential wiring, which pairs the inputs and halves the count. A 5-bit gap field puts idle time after each conversion, counted in prescaled ticks. Zero in the gap field gives back-to-back conversions. A simultaneous-capture option freezes every active channel's sample-hold at the start of a scan, so all channels are sampled at the same instant even though they are converted one at a time.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is held, every result register and every fresh flag reads zero, conv_start and all sh_hold bits are low, and mux_sel is 0.
- R2: Channels are converted in ascending order starting from channel 0. After the last active channel the scan wraps to channel 0. The last active channel is MAX_CH-1 when the type bit is 0 and MAX_CH/2-1 when it is 1.
- R3: The type bit is sampled during reset and again at each wrap to channel 0. A change made part-way through a scan takes effect only when the scan next wraps.
- R4: Each conversion runs as follows: one hold cycle, then a one-cycle conv_start with mux_sel showing the channel, then a wait of any length for conv_done. A conv_done that arrives outside this wait is ignored, and no result or flag changes.
- R5: On the cycle conv_done is accepted, conv_data is written into the result register of the channel on mux_sel. Channel k occupies bits k*DATA_W upward in ch_result. The same cycle sets that channel's fresh flag.
- R6: A high rd_ack bit clears that channel's fresh flag at the next edge. When a capture for the same channel happens in the same cycle, the capture wins and the flag stays set.
- R7: Let the gap field be G and let conv_done arrive L cycles after conv_start. The next conv_start then comes L+2+G*PRESCALE cycles after the previous one. G=0 gives L+2.
- R8: The gap field is sampled on the cycle conv_done is accepted. Changing it during a gap does not change the gap already running.
- R9: With simultaneous capture off, only the selected channel's sh_hold bit is high. It is set from the conv_start cycle until its conv_done is accepted, and all bits are low during a gap.
- R10: With simultaneous capture on, the hold cycle of channel 0 sets sh_hold for every active channel. Each bit is released when its own conversion completes. For example, the start of channel 1 shows 8'hFE in differential mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_diff | input | 1 | Type bit: 0 selects single-ended (MAX_CH channels), 1 selects differential (MAX_CH/2 channels) |
| cfg_simul | input | 1 | Simultaneous sample-hold capture enable |
| cfg_gap | input | GAP_W | Idle gap after each conversion, in prescaled ticks |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | DATA_W | Converter result, valid together with conv_done |
| mux_sel | output | $clog2(MAX_CH) | Selected input channel |
| sh_hold | output | MAX_CH | Per-channel sample-hold control, high means hold |
| rd_ack | input | MAX_CH | Per-channel host acknowledge that clears the fresh flag |
| ch_result | output | MAX_CH*DATA_W | Packed per-channel result registers |
| ch_fresh | output | MAX_CH | Per-channel new-data flags |

## Verification
The assertions check on every cycle the properties that hold at each step of the handshake. The start pulse never lasts two cycles, and the selected channel is always held while its start pulse is high. mux_sel only moves after an accepted completion and stays in range in differential mode. A capture always leaves its channel's flag set, and an acknowledge without a colliding capture always clears it. The bench scenarios show the behaviour that needs a whole scan or a timed gap to see. This covers the visiting order across a type-bit change, the start-to-start spacing under different gap values including a value changed during a gap, a completion pulse arriving during a gap, the capture-over-acknowledge collision, and the group hold pattern of simultaneous capture.

// File: rtl/adc_scan_pkg.sv
// Shared types for the scan sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_scan_pkg;

    // Phases of one channel conversion
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,  // freeze the selected channel
        ST_START = 2'd1,  // pulse the converter start
        ST_WAIT  = 2'd2,  // wait for converter completion
        ST_GAP   = 2'd3   // programmed idle time between samples
    } scan_state_t;

endpackage

// File: rtl/adc_scan_ctrl.sv
// Conversion sequencer: walks the channel pointer, runs the hold/start/wait/gap
// phases and latches the scan width at each wrap.
// Assumes: conv_done is a single-cycle pulse; gap_expire only pulses in ST_GAP.
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int MAX_CH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_diff,
    input  logic                      gap_nz,
    input  logic                      conv_done,
    input  logic                      gap_expire,
    output logic [$clog2(MAX_CH)-1:0] ch_o,
    output logic                      mode_o,
    output logic                      capture_o,
    output logic                      gap_load_o,
    output logic                      conv_start_o,
    output logic                      hold_set_o
);
    localparam int CH_W    = $clog2(MAX_CH);
    localparam int HALF_CH = MAX_CH / 2;

    scan_state_t      state;
    logic [CH_W-1:0]  ch_q;
    logic             mode_q;
    logic [CH_W-1:0]  last_ch;

    // Highest channel of the current scan width
    assign last_ch = mode_q ? CH_W'(HALF_CH - 1) : CH_W'(MAX_CH - 1);

    // Decoded phase strobes
    always_comb begin
        capture_o    = (state == ST_WAIT) && conv_done;
        gap_load_o   = capture_o && gap_nz;
        conv_start_o = (state == ST_START);
        hold_set_o   = (state == ST_HOLD);
    end

    // Phase register, channel pointer and scan width update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_HOLD;
            ch_q   <= '0;
            mode_q <= cfg_diff;
        end else begin
            case (state)
                ST_HOLD:  state <= ST_START;
                ST_START: state <= ST_WAIT;
                ST_WAIT: begin
                    if (conv_done) begin
                        state <= gap_nz ? ST_GAP : ST_HOLD;
                        if (ch_q == last_ch) begin
                            ch_q   <= '0;
                            mode_q <= cfg_diff;
                        end else begin
                            ch_q <= ch_q + CH_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_expire) state <= ST_HOLD;
                end
                default: state <= ST_HOLD;
            endcase
        end
    end

    assign ch_o   = ch_q;
    assign mode_o = mode_q;

endmodule

// File: rtl/adc_gap_timer.sv
// Inter-sample gap timer: after a load, counts len prescaled ticks of PRESCALE
// cycles each and pulses expire on the final cycle.
// Assumes: load is only given with len >= 1.
module adc_gap_timer #(
    parameter int GAP_W    = 5,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] len,
    output logic             expire
);
    logic             busy;
    logic [GAP_W-1:0] len_q;
    logic [GAP_W-1:0] tcnt;
    logic             tick;

    generate
        if (PRESCALE > 1) begin : g_div
            localparam int PRE_W = $clog2(PRESCALE);
            logic [PRE_W-1:0] pre;

            // Prescaler, restarted on every load
            always_ff @(posedge clk) begin
                if (!rst_n)             pre <= '0;
                else if (load)          pre <= '0;
                else if (busy) begin
                    if (pre == PRE_W'(PRESCALE - 1)) pre <= '0;
                    else                             pre <= pre + PRE_W'(1);
                end
            end

            assign tick = busy && (pre == PRE_W'(PRESCALE - 1));
        end else begin : g_nodiv
            assign tick = busy;
        end
    endgenerate

    assign expire = tick && (tcnt == len_q - GAP_W'(1));

    // Tick counter and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            len_q <= '0;
            tcnt  <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            len_q <= len;
            tcnt  <= '0;
        end else if (tick) begin
            if (expire) busy <= 1'b0;
            else        tcnt <= tcnt + GAP_W'(1);
        end
    end

endmodule

// File: rtl/adc_result_bank.sv
// Per-channel storage: result word, fresh flag and sample-hold bit, one slice
// per channel.
// Assumes: capture and hold_set never coincide.
module adc_result_bank #(
    parameter int MAX_CH = 16,
    parameter int DATA_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture,
    input  logic [$clog2(MAX_CH)-1:0] ch,
    input  logic [DATA_W-1:0]         data,
    input  logic [MAX_CH-1:0]         rd_ack,
    input  logic                      hold_set,
    input  logic                      hold_all,
    input  logic [MAX_CH-1:0]         active_mask,
    output logic [MAX_CH*DATA_W-1:0]  results,
    output logic [MAX_CH-1:0]         fresh,
    output logic [MAX_CH-1:0]         hold
);
    localparam int CH_W = $clog2(MAX_CH);

    for (genvar g = 0; g < MAX_CH; g++) begin : g_ch
        logic sel;
        logic hit;

        assign sel = (ch == CH_W'(g));
        assign hit = capture && sel;

        // Result word for this channel
        always_ff @(posedge clk) begin
            if (!rst_n)   results[g*DATA_W +: DATA_W] <= '0;
            else if (hit) results[g*DATA_W +: DATA_W] <= data;
        end

        // Fresh flag: capture sets it and takes priority over acknowledge
        always_ff @(posedge clk) begin
            if (!rst_n)         fresh[g] <= 1'b0;
            else if (hit)       fresh[g] <= 1'b1;
            else if (rd_ack[g]) fresh[g] <= 1'b0;
        end

        // Sample-hold: set alone or as a group, released by its own capture
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold[g] <= 1'b0;
            else if (hit)
                hold[g] <= 1'b0;
            else if (hold_set && (sel || (hold_all && active_mask[g])))
                hold[g] <= 1'b1;
        end
    end

endmodule

// File: rtl/adc_scan_seq.sv
// Top of the multiplexed scan sequencer: connects the sequencer, the gap timer
// and the per-channel bank, and derives the active-channel mask.
// Assumes: MAX_CH is a power of two of at least 4; converter handshake as in
// adc_scan_ctrl.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int MAX_CH   = 16,
    parameter int DATA_W   = 12,
    parameter int GAP_W    = 5,
    parameter int PRESCALE = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_diff,
    input  logic                      cfg_simul,
    input  logic [GAP_W-1:0]          cfg_gap,
    output logic                      conv_start,
    input  logic                      conv_done,
    input  logic [DATA_W-1:0]         conv_data,
    output logic [$clog2(MAX_CH)-1:0] mux_sel,
    output logic [MAX_CH-1:0]         sh_hold,
    input  logic [MAX_CH-1:0]         rd_ack,
    output logic [MAX_CH*DATA_W-1:0]  ch_result,
    output logic [MAX_CH-1:0]         ch_fresh
);
    localparam int CH_W    = $clog2(MAX_CH);
    localparam int HALF_CH = MAX_CH / 2;

    logic              capture;
    logic              mode_q;
    logic              gap_load;
    logic              gap_expire;
    logic              hold_set;
    logic              hold_all;
    logic [MAX_CH-1:0] active_mask;

    // Channels inside the current scan width
    for (genvar g = 0; g < MAX_CH; g++) begin : g_mask
        if (g < HALF_CH) begin : g_low
            assign active_mask[g] = 1'b1;
        end else begin : g_high
            assign active_mask[g] = !mode_q;
        end
    end

    // Group hold is applied on the hold cycle of channel 0
    assign hold_all = cfg_simul && (mux_sel == CH_W'(0));

    adc_scan_ctrl #(
        .MAX_CH (MAX_CH)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_diff     (cfg_diff),
        .gap_nz       (cfg_gap != '0),
        .conv_done    (conv_done),
        .gap_expire   (gap_expire),
        .ch_o         (mux_sel),
        .mode_o       (mode_q),
        .capture_o    (capture),
        .gap_load_o   (gap_load),
        .conv_start_o (conv_start),
        .hold_set_o   (hold_set)
    );

    adc_gap_timer #(
        .GAP_W    (GAP_W),
        .PRESCALE (PRESCALE)
    ) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (gap_load),
        .len    (cfg_gap),
        .expire (gap_expire)
    );

    adc_result_bank #(
        .MAX_CH (MAX_CH),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .ch          (mux_sel),
        .data        (conv_data),
        .rd_ack      (rd_ack),
        .hold_set    (hold_set),
        .hold_all    (hold_all),
        .active_mask (active_mask),
        .results     (ch_result),
        .fresh       (ch_fresh),
        .hold        (sh_hold)
    );

endmodule

// File: rtl/adc_scan_seq_chk.sv
// Cycle-level checks of the scan sequencer, bound into every adc_scan_seq.
// Assumes: synchronous active-low reset; checks are idle while it is low.
module adc_scan_seq_chk #(
    parameter int MAX_CH = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      conv_start,
    input logic [$clog2(MAX_CH)-1:0] mux_sel,
    input logic [MAX_CH-1:0]         sh_hold,
    input logic [MAX_CH-1:0]         ch_fresh,
    input logic [MAX_CH-1:0]         rd_ack,
    input logic                      capture,
    input logic                      mode_q
);
    localparam int CH_W    = $clog2(MAX_CH);
    localparam int HALF_CH = MAX_CH / 2;

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R9
    hold_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> sh_hold[mux_sel]);

    // R2
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (mux_sel < CH_W'(HALF_CH)));

    // R2
    sel_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_sel) |-> $past(capture));

    // R5
    capture_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ch_fresh[$past(mux_sel)]);

    for (genvar g = 0; g < MAX_CH; g++) begin : g_ack
        // R6
        ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_ack[g] && !(capture && (mux_sel == CH_W'(g)))) |=> !ch_fresh[g]);
    end

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.MAX_CH(MAX_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .mux_sel    (mux_sel),
    .sh_hold    (sh_hold),
    .ch_fresh   (ch_fresh),
    .rd_ack     (rd_ack),
    .capture    (capture),
    .mode_q     (mode_q)
);

// File: tb/test_adc_scan_seq.sv
// Directed bench for adc_scan_seq with a behavioural converter model.
module test_adc_scan_seq;
    localparam int MAX_CH = 16;
    localparam int DATA_W = 12;
    localparam int GAP_W  = 5;
    localparam int P      = 4;   // prescale
    localparam int LAT    = 5;   // converter latency, start to done

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  cfg_diff = 1'b0;
    logic                  cfg_simul = 1'b0;
    logic [GAP_W-1:0]      cfg_gap = '0;
    logic                  conv_start;
    logic                  conv_done;
    logic [DATA_W-1:0]     conv_data;
    logic [3:0]            mux_sel;
    logic [MAX_CH-1:0]     sh_hold;
    logic [MAX_CH-1:0]     rd_ack = '0;
    logic [MAX_CH*DATA_W-1:0] ch_result;
    logic [MAX_CH-1:0]     ch_fresh;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // converter model log
    int          n_conv, n_done, pend, spur_cnt = 0, spur_served;
    logic [11:0] pend_data;
    int          log_ch   [64];
    logic [15:0] log_hold [64];
    int          log_t    [64];
    logic [11:0] log_d    [64];

    adc_scan_seq #(
        .MAX_CH(MAX_CH), .DATA_W(DATA_W), .GAP_W(GAP_W), .PRESCALE(P)
    ) i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .cfg_diff(cfg_diff), .cfg_simul(cfg_simul),
        .cfg_gap(cfg_gap), .conv_start(conv_start), .conv_done(conv_done),
        .conv_data(conv_data), .mux_sel(mux_sel), .sh_hold(sh_hold),
        .rd_ack(rd_ack), .ch_result(ch_result), .ch_fresh(ch_fresh)
    );

    initial forever #4 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Converter: done LAT cycles after start; optional stray done on request
    initial begin
        conv_done = 1'b0; conv_data = '0; pend = 0;
        n_conv = 0; n_done = 0; spur_served = 0; pend_data = '0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (!rst_n) begin
                pend = 0; n_conv = 0; n_done = 0;
            end else begin
                if (pend > 0) begin
                    pend--;
                    if (pend == 0) begin
                        conv_done = 1'b1; conv_data = pend_data; n_done++;
                    end
                end else if (spur_cnt != spur_served) begin
                    conv_done = 1'b1; conv_data = 12'hABC; spur_served++;
                end
                if (conv_start) begin
                    pend_data = {mux_sel, n_conv[7:0]};
                    if (n_conv < 64) begin
                        log_ch[n_conv]   = int'(mux_sel);
                        log_hold[n_conv] = sh_hold;
                        log_t[n_conv]    = cyc;
                        log_d[n_conv]    = pend_data;
                    end
                    n_conv++;
                    pend = LAT;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] res(input int c);
        return ch_result[c*DATA_W +: DATA_W];
    endfunction

    task automatic do_reset(input logic diff, input logic [4:0] gap, input logic simul);
        @(negedge clk);
        rst_n = 1'b0; cfg_diff = diff; cfg_gap = gap; cfg_simul = simul; rd_ack = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic settle(input int k);
        wait (n_done >= k);
        @(negedge clk);
        #1;
    endtask

    // R2 R5 R7 R9: full single-ended scan with no gap
    task automatic t_scan_se();
        do_reset(1'b0, 5'd0, 1'b0);
        settle(17);
        for (int i = 0; i < 17; i++) chk("R2 order", log_ch[i], i % 16);
        chk("R9 hold ch0", log_hold[0], 16'h0001);
        chk("R9 hold ch5", log_hold[5], 16'h0020);
        for (int c = 0; c < 16; c++)
            chk("R5 result", res(c), (c == 0) ? log_d[16] : log_d[c]);
        chk("R5 fresh", ch_fresh, 16'hFFFF);
        chk("R7 period gap0", log_t[1] - log_t[0], LAT + 2);
        chk("R2 scan rate", log_t[16] - log_t[0], 16 * (LAT + 2));
    endtask

    // R6: acknowledge clears; capture beats acknowledge on the same channel
    task automatic t_ack();
        int c, o;
        do begin
            @(negedge clk);
            #1;
        end while (!conv_done);
        c = int'(mux_sel);
        o = (c + 3) % 16;
        rd_ack = (16'h1 << c) | (16'h1 << o);
        @(negedge clk);
        rd_ack = '0;
        #1;
        chk("R6 capture wins", ch_fresh[c], 1);
        chk("R6 ack clears", ch_fresh[o], 0);
        repeat (2) @(negedge clk);
        #1;
        chk("R6 stays clear", ch_fresh[o], 0);
    endtask

    // R1: reset clears state left by earlier activity
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 fresh", ch_fresh, 0);
        chk("R1 results", (ch_result == '0), 1);
        chk("R1 start", conv_start, 0);
        chk("R1 hold", sh_hold, 0);
        chk("R1 sel", mux_sel, 0);
    endtask

    // R2 R3: differential width from reset, switch to single-ended mid-scan
    task automatic t_mode();
        do_reset(1'b1, 5'd0, 1'b0);
        settle(9);
        for (int i = 0; i < 9; i++) chk("R2 diff order", log_ch[i], i % 8);
        cfg_diff = 1'b0;
        settle(33);
        for (int i = 9; i < 33; i++)
            chk("R3 change at wrap", log_ch[i], (i < 16) ? i - 8 : (i - 16) % 16);
    endtask

    // R4 R7 R8 R9: gap length, gap field sampled at done, stray done ignored
    task automatic t_gap();
        int c;
        do_reset(1'b1, 5'd3, 1'b0);
        settle(2);
        chk("R9 no hold in gap", sh_hold, 0);
        c = int'(mux_sel);
        cfg_gap = 5'd31;
        spur_cnt++;
        repeat (3) @(negedge clk);
        #1;
        chk("R4 stray done flag", ch_fresh[c], 0);
        chk("R4 stray done data", res(c), 0);
        wait (n_conv >= 4);
        @(negedge clk);
        chk("R8 running gap kept", log_t[2] - log_t[1], LAT + 2 + 3 * P);
        chk("R7 max gap", log_t[3] - log_t[2], LAT + 2 + 31 * P);
    endtask

    // R10: group hold in simultaneous mode
    task automatic t_simul();
        do_reset(1'b1, 5'd0, 1'b1);
        settle(9);
        chk("R10 group diff", log_hold[0], 16'h00FF);
        chk("R10 release ch0", log_hold[1], 16'h00FE);
        chk("R10 last ch", log_hold[7], 16'h0080);
        chk("R10 regroup", log_hold[8], 16'h00FF);
        do_reset(1'b0, 5'd0, 1'b1);
        wait (n_conv >= 1);
        @(negedge clk);
        chk("R10 group se", log_hold[0], 16'hFFFF);
    endtask

    initial begin
        do_reset(1'b0, 5'd0, 1'b0);
        t_scan_se();
        t_ack();
        t_reset();
        t_mode();
        t_gap();
        t_simul();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        wait (cyc >= 100000);
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

endmodule